// File: doc/BRIEF.md
# Interrupt Mask Set/Clear Controller

This block decides when the device raises its single interrupt request line. It holds a 32-bit enable mask and a 32-bit vector of latched interrupt causes. Other logic in the device reports events as one-cycle pulses, and each pulse sets its cause bit. The request output rises when any latched cause has its enable bit at 1.

Software changes the mask through two write-only views. In the set view, every 1 that is written turns an enable bit on. In the clear view, every 1 that is written turns an enable bit off. A written 0 has no effect in either view, so no read-modify-write sequence is needed. Reading the cause vector returns it and clears it at the same time.

A control input lets a write of all ones to the set view also emit a one-cycle strobe. That strobe resets the interrupt moderation timers, which sit outside this block. Certain bit positions are reserved. They never hold state and never take part in the request.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the mask and the cause vector are 0, and `irq` and `tmr_clr` are 0.
- R2: A read with `rd_sel`=0 returns the current mask on `rd_data` in the same cycle. A mask bit at 1 enables its source and a bit at 0 disables it.
- R3: A write to the set view (`set_we`) sets each mask bit whose `set_data` bit is 1. Bits written as 0 keep their previous value.
- R4: A write to the clear view (`clr_we`) clears each mask bit whose `clr_data` bit is 1. Bits written as 0 keep their previous value.
- R5: When both views are written in the same cycle and both target a bit, that bit ends up cleared.
- R6: Reserved positions are 3, 10, 11, 13, 20 and 23 to 31 (mask 0xFF902C08). At these positions the mask and the cause vector read as 0, and writes and event pulses are ignored. Writing all ones to the set view therefore leaves the mask at 0x006FD3F7.
- R7: A pulse on bit n of `evt` sets cause bit n at the next clock edge. The bit stays set until the cause vector is read.
- R8: A read with `rd_sel`=1 returns the cause vector and clears it at the same edge. An event arriving in that same cycle stays latched.
- R9: `irq` is registered and equals the OR over all bits of (cause AND mask), one clock later. A cause whose mask bit is 0 does not raise `irq`. `irq` falls one clock after its driving causes or masks are cleared.
- R10: When `tmr_clr_en` is 1 and the set view is written with all ones, `tmr_clr` is 1 for exactly the next cycle.
- R11: `tmr_clr` stays 0 when a set write is not all ones, or when `tmr_clr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_we | input | 1 | Write strobe for the mask set view |
| set_data | input | 32 | Bits to enable (write 1 to set) |
| clr_we | input | 1 | Write strobe for the mask clear view |
| clr_data | input | 32 | Bits to disable (write 1 to clear) |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Read target: 0 = mask, 1 = cause (read clears) |
| rd_data | output | 32 | Read data, valid in the cycle of `rd_en` |
| evt | input | 32 | One-cycle event pulses, one per cause bit |
| tmr_clr_en | input | 1 | Allows an all-ones set write to clear the timers |
| irq | output | 1 | Registered interrupt request |
| tmr_clr | output | 1 | One-cycle timer-clear strobe |

## Verification
The assertions assume three things about the inputs. Write strobes and the read strobe are sampled only on clock edges. `rd_sel` is meaningful only while `rd_en` is 1. Event pulses may arrive on any bit, reserved bits included, and in any cycle. The bench drives every input one time unit after a rising edge and holds it through the next edge, so each strobe lasts exactly one cycle. It also sends events to reserved positions and fires events in the same cycle as a cause read, so the assertions see these edge cases under legal timing.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
   localparam int unsigned IMC_W = 32;
   localparam logic [IMC_W-1:0] IMC_RSVD_DEFAULT = 32'hFF90_2C08;

   typedef enum logic {
      RD_MASK  = 1'b0,
      RD_CAUSE = 1'b1
   } imc_rd_sel_e;
endpackage

// File: rtl/imc_mask_reg.sv
module imc_mask_reg #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] RSVD = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic [W-1:0] set_data,
   input  logic         clr_we,
   input  logic [W-1:0] clr_data,
   output logic [W-1:0] mask_q
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      if (RSVD[b]) begin : g_rsvd
         assign mask_q[b] = 1'b0;
      end else begin : g_live
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               bit_q <= 1'b0;
            end else if (clr_we && clr_data[b]) begin
               bit_q <= 1'b0;
            end else if (set_we && set_data[b]) begin
               bit_q <= 1'b1;
            end
         end
         assign mask_q[b] = bit_q;
      end
   end
endmodule

// File: rtl/imc_cause_reg.sv
module imc_cause_reg #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] RSVD = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         rd_clr,
   output logic [W-1:0] cause_q
);
   localparam logic [W-1:0] LIVE = ~RSVD;

   logic [W-1:0] held;
   logic [W-1:0] cause_d;

   always_comb begin
      held    = rd_clr ? '0 : cause_q;
      cause_d = (held | evt) & LIVE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= cause_d;
   end
endmodule

// File: rtl/imc_req_out.sv
module imc_req_out #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cause_q,
   input  logic [W-1:0] mask_q,
   input  logic         set_we,
   input  logic [W-1:0] set_data,
   input  logic         tmr_clr_en,
   output logic         irq,
   output logic         tmr_clr
);
   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

   logic fire;
   assign fire = set_we && tmr_clr_en && (set_data == ALL_ONES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq     <= 1'b0;
         tmr_clr <= 1'b0;
      end else begin
         irq     <= |(cause_q & mask_q);
         tmr_clr <= fire;
      end
   end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
   import irq_mask_pkg::*;
#(
   parameter int unsigned DATA_W = IMC_W,
   parameter logic [DATA_W-1:0] RSVD_BITS = IMC_RSVD_DEFAULT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic [DATA_W-1:0] set_data,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] clr_data,
   input  logic              rd_en,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] evt,
   input  logic              tmr_clr_en,
   output logic              irq,
   output logic              tmr_clr
);
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
      $error("irq_mask_ctrl: DATA_W must be between 1 and 64");
   end
   if (RSVD_BITS == {DATA_W{1'b1}}) begin : g_all_rsvd
      $error("irq_mask_ctrl: every bit is reserved");
   end

   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] cause_q;
   logic              rd_clr;

   assign rd_clr  = rd_en && (rd_sel == RD_CAUSE);
   assign rd_data = !rd_en              ? '0 :
                    (rd_sel == RD_MASK) ? mask_q : cause_q;

   imc_mask_reg #(.W(DATA_W), .RSVD(RSVD_BITS)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we   (set_we),
      .set_data (set_data),
      .clr_we   (clr_we),
      .clr_data (clr_data),
      .mask_q   (mask_q)
   );

   imc_cause_reg #(.W(DATA_W), .RSVD(RSVD_BITS)) u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .rd_clr  (rd_clr),
      .cause_q (cause_q)
   );

   imc_req_out #(.W(DATA_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .cause_q    (cause_q),
      .mask_q     (mask_q),
      .set_we     (set_we),
      .set_data   (set_data),
      .tmr_clr_en (tmr_clr_en),
      .irq        (irq),
      .tmr_clr    (tmr_clr)
   );
endmodule

// File: rtl/irq_mask_chk.sv
module irq_mask_chk #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] RSVD = '0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         set_we,
   input logic [W-1:0] set_data,
   input logic         clr_we,
   input logic [W-1:0] clr_data,
   input logic         rd_en,
   input logic         rd_sel,
   input logic [W-1:0] evt,
   input logic         tmr_clr_en,
   input logic [W-1:0] mask_q,
   input logic [W-1:0] cause_q,
   input logic         irq,
   input logic         tmr_clr
);
   localparam logic [W-1:0] ONES = {W{1'b1}};

   AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask_q | cause_q) & RSVD) == '0); // R6
   AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !clr_we) |=> ((mask_q & $past(mask_q)) == $past(mask_q))); // R3
   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && !clr_we) |=> ((mask_q & $past(set_data & ~RSVD)) == $past(set_data & ~RSVD))); // R3
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((mask_q & $past(clr_data)) == '0)); // R5
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(mask_q)); // R4
   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_sel) |=> ((cause_q & ~$past(evt)) == '0)); // R8
   AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause_q & $past(evt & ~RSVD)) == $past(evt & ~RSVD))); // R7
   AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(|(cause_q & mask_q)))); // R9
   AST_TMR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (tmr_clr == $past(set_we && tmr_clr_en && (set_data == ONES)))); // R10
endmodule

bind irq_mask_ctrl irq_mask_chk #(.W(DATA_W), .RSVD(RSVD_BITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .set_we     (set_we),
   .set_data   (set_data),
   .clr_we     (clr_we),
   .clr_data   (clr_data),
   .rd_en      (rd_en),
   .rd_sel     (rd_sel),
   .evt        (evt),
   .tmr_clr_en (tmr_clr_en),
   .mask_q     (mask_q),
   .cause_q    (cause_q),
   .irq        (irq),
   .tmr_clr    (tmr_clr)
);

// File: tb/irq_mask_ctrl_test.sv
`timescale 1ns/1ps
module irq_mask_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        set_we = 1'b0;
   logic [31:0] set_data = '0;
   logic        clr_we = 1'b0;
   logic [31:0] clr_data = '0;
   logic        rd_en = 1'b0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data;
   logic [31:0] evt = '0;
   logic        tmr_clr_en = 1'b0;
   logic        irq;
   logic        tmr_clr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      logic [31:0] val;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   irq_mask_ctrl uut (
      .clk(clk), .rst_n(rst_n), .set_we(set_we), .set_data(set_data),
      .clr_we(clr_we), .clr_data(clr_data), .rd_en(rd_en), .rd_sel(rd_sel),
      .rd_data(rd_data), .evt(evt), .tmr_clr_en(tmr_clr_en),
      .irq(irq), .tmr_clr(tmr_clr)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares read data against the scoreboard queue
   always @(negedge clk) begin
      if (rd_en) begin
         if (sb.size() == 0) begin
            check(rd_data, 32'hxxxx_xxxx, "scoreboard underflow");
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(rd_data, e.val, e.tag);
         end
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic se, input logic [31:0] sd,
                     input logic ce, input logic [31:0] cd);
      step();
      set_we = se; set_data = sd; clr_we = ce; clr_data = cd;
      step();
      set_we = 0; set_data = '0; clr_we = 0; clr_data = '0;
   endtask

   task automatic rd(input logic sel, input logic [31:0] exp, input string tag,
                     input logic [31:0] ev = '0);
      exp_t e;
      e.val = exp; e.tag = tag;
      sb.push_back(e);
      step();
      rd_en = 1; rd_sel = sel; evt = ev;
      step();
      rd_en = 0; evt = '0;
   endtask

   task automatic pulse(input logic [31:0] ev);
      step();
      evt = ev;
      step();
      evt = '0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      check({31'b0, irq}, 32'h0, "R1 irq after reset");
      check({31'b0, tmr_clr}, 32'h0, "R1 tmr_clr after reset");
      rd(0, 32'h0, "R1 mask after reset");
      rd(1, 32'h0, "R1 cause after reset");

      wr(1, 32'h0000_00FF, 0, '0);
      rd(0, 32'h0000_00F7, "R3 R6 set write, bit 3 reserved");
      wr(1, 32'h0, 0, '0);
      rd(0, 32'h0000_00F7, "R3 zeros in set view ignored");
      wr(0, '0, 1, 32'h0000_0003);
      rd(0, 32'h0000_00F4, "R4 clear view write");
      wr(0, '0, 1, 32'h0);
      rd(0, 32'h0000_00F4, "R4 zeros in clear view ignored");
      wr(1, 32'h0000_0110, 1, 32'h0000_0010);
      rd(0, 32'h0000_01E4, "R5 clear wins on shared bit");

      pulse(32'h8000_0008);
      rd(1, 32'h0, "R6 reserved events dropped");

      pulse(32'h0000_0001);
      step();
      check({31'b0, irq}, 32'h0, "R9 masked cause keeps irq low");
      pulse(32'h0000_0004);
      check({31'b0, irq}, 32'h0, "R9 irq one cycle late");
      step();
      check({31'b0, irq}, 32'h1, "R9 irq raised");
      rd(1, 32'h0000_0005, "R7 causes latched", 32'h0000_0040);
      check({31'b0, irq}, 32'h1, "R9 irq held by same-cycle event");
      wr(0, '0, 1, 32'h0000_0040);
      check({31'b0, irq}, 32'h1, "R9 irq falls one cycle after mask clear");
      step();
      check({31'b0, irq}, 32'h0, "R9 irq low after mask clear");
      rd(1, 32'h0000_0040, "R8 event during read stays latched");
      rd(1, 32'h0, "R8 read cleared cause");

      tmr_clr_en = 0;
      wr(1, 32'hFFFF_FFFF, 0, '0);
      check({31'b0, tmr_clr}, 32'h0, "R11 no strobe with enable off");
      tmr_clr_en = 1;
      wr(1, 32'hFFFF_FFFE, 0, '0);
      check({31'b0, tmr_clr}, 32'h0, "R11 no strobe without all ones");
      wr(1, 32'hFFFF_FFFF, 0, '0);
      check({31'b0, tmr_clr}, 32'h1, "R10 strobe after all-ones write");
      step();
      check({31'b0, tmr_clr}, 32'h0, "R10 strobe lasts one cycle");
      rd(0, 32'h006F_D3F7, "R2 R6 full mask read");

      repeat (2) step();
      check(sb.size(), 32'h0, "R2 all reads observed");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule